// File: doc/BRIEF.md
# DMA Ready Signal Generator

This block drives the two active-low DMA request lines of one serial channel: a transmit request, which asks a DMA controller to write more characters into the transmit FIFO, and a receive request, which asks it to read characters out of the receive FIFO. It observes the fill levels of both 64-entry FIFOs, the FIFO enable, a transfer-mode select and the programmed transmit and receive trigger levels. It does not hold the FIFOs or take part in the transfers.

Two transfer styles are supported. In single-character style a request tracks one character of space or data: transmit asks for data only while its FIFO is empty, and receive asks while any character waits. In block style each request has hysteresis. Transmit turns on once enough free slots exist to absorb a burst and stays on until the FIFO fills. Receive turns on once the trigger number of characters has arrived and stays on until the FIFO drains. With the FIFOs disabled, single-character style applies whatever the mode select says. Both outputs are registered and change one clock after the inputs that cause the change.

Top module: `dma_ready_gen`

## Requirements
- R1: While `rst` is 1 at a rising clock edge, both `tx_rdy_n` and `rx_rdy_n` are 1 after that edge.
- R2: Outputs are registered: each output after a rising edge depends only on the inputs sampled at that edge and the outputs before it.
- R3: Block style is in effect only when `fifo_en` is 1 and `blk_mode` is 1; every other combination gives single-character style.
- R4: In single-character style, `tx_rdy_n` is 0 when `tx_level` is 0 and 1 otherwise.
- R5: In single-character style, `rx_rdy_n` is 0 when `rx_level` is non-zero and 1 when it is 0.
- R6: In block style, when `tx_level` is below 64 and the free count 64 minus `tx_level` is at least `tx_trig`, `tx_rdy_n` becomes 0 (a trigger of 0 counts as always reached).
- R7: In block style, when `tx_level` is 64, `tx_rdy_n` becomes 1.
- R8: In block style, when `tx_level` is below 64 and the free count is below `tx_trig`, `tx_rdy_n` keeps its previous value, including the value it had before a switch into block style.
- R9: In block style, when `rx_level` is non-zero and at least `rx_trig`, `rx_rdy_n` becomes 0.
- R10: In block style, when `rx_level` is 0, `rx_rdy_n` becomes 1.
- R11: In block style, when `rx_level` is non-zero and below `rx_trig`, `rx_rdy_n` keeps its previous value, including across a switch into block style.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_en | input | 1 | FIFOs enabled |
| blk_mode | input | 1 | 1 selects block transfer style |
| tx_level | input | 7 | Characters held in the transmit FIFO (0 to 64) |
| rx_level | input | 7 | Characters held in the receive FIFO (0 to 64) |
| tx_trig | input | 7 | Free slots needed to raise the transmit request in block style |
| rx_trig | input | 7 | Characters needed to raise the receive request in block style |
| tx_rdy_n | output | 1 | Transmit DMA request, active low |
| rx_rdy_n | output | 1 | Receive DMA request, active low |

## Verification
The assertions check on every cycle that a full transmit FIFO or an empty receive FIFO drops the matching request one clock later, that single-character style follows the levels exactly, and that in block style each request turns on at its trigger and otherwise holds. Only the bench scenarios show the hysteresis as a whole: a request staying on while the level wanders back below its trigger, the state carried over when the style switches from single to block, and the extreme trigger settings 0 and 64.

// File: rtl/dma_rdy_pkg.sv
package dma_rdy_pkg;

    typedef enum logic {
        XFER_SINGLE = 1'b0,
        XFER_BLOCK  = 1'b1
    } xfer_mode_e;

    typedef enum logic [1:0] {
        REQ_HOLD = 2'd0,
        REQ_ON   = 2'd1,
        REQ_OFF  = 2'd2
    } req_act_e;

    // Condition flags for one FIFO as seen by a request channel.
    typedef struct packed {
        logic empty;
        logic full;
        logic reach;
    } lvl_flags_t;

    function automatic xfer_mode_e pick_mode(input logic fifo_on, input logic blk_sel);
        return (fifo_on && blk_sel) ? XFER_BLOCK : XFER_SINGLE;
    endfunction

    // Active-low request value after applying an action to the current one.
    function automatic logic apply_act(input req_act_e act, input logic cur_n);
        logic nxt;
        unique case (act)
            REQ_ON:  nxt = 1'b0;
            REQ_OFF: nxt = 1'b1;
            default: nxt = cur_n;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/dma_mode_sel.sv
module dma_mode_sel
    import dma_rdy_pkg::*;
(
    input  logic       fifo_en,
    input  logic       blk_mode,
    output xfer_mode_e mode
);

    always_comb begin
        mode = pick_mode(fifo_en, blk_mode);
    end

endmodule

// File: rtl/dma_rdy_chan.sv
module dma_rdy_chan
    import dma_rdy_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LVL_W = 7,
    parameter bit IS_TX = 1'b1
)(
    input  logic             clk,
    input  logic             rst,
    input  xfer_mode_e       mode,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] trig,
    output logic             req_n
);

    localparam int CW = LVL_W + 1;
    localparam logic [CW-1:0]    DEPTH_W = CW'(DEPTH);
    localparam logic [LVL_W-1:0] FULL_L  = LVL_W'(DEPTH);

    lvl_flags_t flags;
    req_act_e   act;
    logic       req_q;

    generate
        if (IS_TX) begin : g_tx
            logic [CW-1:0] space;
            always_comb begin
                space       = DEPTH_W - {1'b0, level};
                flags.empty = (level == '0);
                flags.full  = (level == FULL_L);
                flags.reach = (space >= {1'b0, trig});
            end
            always_comb begin
                if (mode == XFER_SINGLE) begin
                    act = flags.empty ? REQ_ON : REQ_OFF;
                end else if (flags.full) begin
                    act = REQ_OFF;
                end else if (flags.reach) begin
                    act = REQ_ON;
                end else begin
                    act = REQ_HOLD;
                end
            end
        end else begin : g_rx
            always_comb begin
                flags.empty = (level == '0);
                flags.full  = (level == FULL_L);
                flags.reach = (level >= trig);
            end
            always_comb begin
                if (flags.empty) begin
                    act = REQ_OFF;
                end else if (mode == XFER_SINGLE) begin
                    act = REQ_ON;
                end else if (flags.reach) begin
                    act = REQ_ON;
                end else begin
                    act = REQ_HOLD;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b1;
        end else begin
            req_q <= apply_act(act, req_q);
        end
    end

    assign req_n = req_q;

endmodule

// File: rtl/dma_ready_gen.sv
module dma_ready_gen
    import dma_rdy_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LVL_W = $clog2(DEPTH + 1)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en,
    input  logic             blk_mode,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_trig,
    input  logic [LVL_W-1:0] rx_trig,
    output logic             tx_rdy_n,
    output logic             rx_rdy_n
);

    xfer_mode_e mode;

    dma_mode_sel u_mode (
        .fifo_en  (fifo_en),
        .blk_mode (blk_mode),
        .mode     (mode)
    );

    dma_rdy_chan #(.DEPTH(DEPTH), .LVL_W(LVL_W), .IS_TX(1'b1)) u_tx (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode),
        .level (tx_level),
        .trig  (tx_trig),
        .req_n (tx_rdy_n)
    );

    dma_rdy_chan #(.DEPTH(DEPTH), .LVL_W(LVL_W), .IS_TX(1'b0)) u_rx (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode),
        .level (rx_level),
        .trig  (rx_trig),
        .req_n (rx_rdy_n)
    );

endmodule

// File: rtl/dma_ready_chk.sv
module dma_ready_chk #(
    parameter int DEPTH = 64,
    parameter int LVL_W = 7
)(
    input logic             clk,
    input logic             rst,
    input logic             fifo_en,
    input logic             blk_mode,
    input logic [LVL_W-1:0] tx_level,
    input logic [LVL_W-1:0] rx_level,
    input logic [LVL_W-1:0] tx_trig,
    input logic [LVL_W-1:0] rx_trig,
    input logic             tx_rdy_n,
    input logic             rx_rdy_n
);

    localparam int CW = LVL_W + 1;
    localparam logic [CW-1:0]    DEPTH_W = CW'(DEPTH);
    localparam logic [LVL_W-1:0] FULL_L  = LVL_W'(DEPTH);

    logic          blk;
    logic [CW-1:0] tx_free;
    assign blk     = fifo_en && blk_mode;
    assign tx_free = DEPTH_W - {1'b0, tx_level};

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (tx_rdy_n && rx_rdy_n));

    // R3 with R4: single style tracks an empty transmit FIFO
    p_single_tx_r4: assert property (@(posedge clk) disable iff (rst)
        !blk |=> (tx_rdy_n == ($past(tx_level) != '0)));

    // R3 with R5: single style tracks a non-empty receive FIFO
    p_single_rx_r5: assert property (@(posedge clk) disable iff (rst)
        !blk |=> (rx_rdy_n == ($past(rx_level) == '0)));

    p_blk_tx_on_r6: assert property (@(posedge clk) disable iff (rst)
        (blk && tx_level != FULL_L && tx_free >= {1'b0, tx_trig}) |=> !tx_rdy_n);

    p_tx_full_off_r7: assert property (@(posedge clk) disable iff (rst)
        (tx_level == FULL_L) |=> tx_rdy_n);

    p_blk_tx_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (blk && tx_level != FULL_L && tx_free < {1'b0, tx_trig}) |=> $stable(tx_rdy_n));

    p_blk_rx_on_r9: assert property (@(posedge clk) disable iff (rst)
        (blk && rx_level != '0 && rx_level >= rx_trig) |=> !rx_rdy_n);

    p_rx_empty_off_r10: assert property (@(posedge clk) disable iff (rst)
        (rx_level == '0) |=> rx_rdy_n);

    p_blk_rx_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (blk && rx_level != '0 && rx_level < rx_trig) |=> $stable(rx_rdy_n));

endmodule

bind dma_ready_gen dma_ready_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .fifo_en  (fifo_en),
    .blk_mode (blk_mode),
    .tx_level (tx_level),
    .rx_level (rx_level),
    .tx_trig  (tx_trig),
    .rx_trig  (rx_trig),
    .tx_rdy_n (tx_rdy_n),
    .rx_rdy_n (rx_rdy_n)
);

// File: tb/dma_ready_gen_tb.sv
module dma_ready_gen_tb;

    localparam int DEPTH = 64;
    localparam int LVL_W = 7;
    localparam int NVEC  = 18;

    typedef struct packed {
        logic             fe;
        logic             bm;
        logic [LVL_W-1:0] txl;
        logic [LVL_W-1:0] rxl;
        logic [LVL_W-1:0] txt;
        logic [LVL_W-1:0] rxt;
        logic             etx;
        logic             erx;
        logic [3:0]       rtx;
        logic [3:0]       rrx;
    } vec_t;

    // Sequence matters: block-style rows depend on the row before.
    localparam vec_t VEC [NVEC] = '{
        '{1'b0,1'b0,7'd0, 7'd0, 7'd8, 7'd8, 1'b0,1'b1,4'd4, 4'd5 },  // R4 R5 empty
        '{1'b0,1'b0,7'd1, 7'd1, 7'd8, 7'd8, 1'b1,1'b0,4'd4, 4'd5 },  // R4 R5 one byte
        '{1'b0,1'b1,7'd0, 7'd5, 7'd8, 7'd8, 1'b0,1'b0,4'd3, 4'd3 },  // R3 fifo off
        '{1'b1,1'b0,7'd64,7'd0, 7'd8, 7'd8, 1'b1,1'b1,4'd4, 4'd5 },  // R4 R5 single
        '{1'b1,1'b1,7'd64,7'd0, 7'd8, 7'd8, 1'b1,1'b1,4'd7, 4'd10},  // R7 R10
        '{1'b1,1'b1,7'd60,7'd4, 7'd8, 7'd8, 1'b1,1'b1,4'd8, 4'd11},  // R8 R11 hold off
        '{1'b1,1'b1,7'd56,7'd8, 7'd8, 7'd8, 1'b0,1'b0,4'd6, 4'd9 },  // R6 R9 exact trig
        '{1'b1,1'b1,7'd40,7'd3, 7'd8, 7'd8, 1'b0,1'b0,4'd6, 4'd11},  // R6 R11
        '{1'b1,1'b1,7'd63,7'd1, 7'd8, 7'd8, 1'b0,1'b0,4'd8, 4'd11},  // R8 R11 hold on
        '{1'b1,1'b1,7'd64,7'd0, 7'd8, 7'd8, 1'b1,1'b1,4'd7, 4'd10},  // R7 R10
        '{1'b1,1'b1,7'd60,7'd7, 7'd8, 7'd8, 1'b1,1'b1,4'd8, 4'd11},  // R8 R11
        '{1'b1,1'b1,7'd30,7'd20,7'd8, 7'd8, 1'b0,1'b0,4'd6, 4'd9 },  // R6 R9
        '{1'b1,1'b0,7'd30,7'd20,7'd8, 7'd8, 1'b1,1'b0,4'd3, 4'd3 },  // R3 single
        '{1'b1,1'b1,7'd62,7'd2, 7'd8, 7'd8, 1'b1,1'b0,4'd8, 4'd11},  // R8 R11 carry-over
        '{1'b1,1'b1,7'd0, 7'd64,7'd64,7'd64,1'b0,1'b0,4'd6, 4'd9 },  // R6 R9 trig 64
        '{1'b1,1'b1,7'd1, 7'd63,7'd64,7'd64,1'b0,1'b0,4'd8, 4'd11},  // R8 R11 trig 64
        '{1'b1,1'b1,7'd10,7'd5, 7'd0, 7'd0, 1'b0,1'b0,4'd6, 4'd9 },  // R6 R9 trig 0
        '{1'b1,1'b1,7'd64,7'd0, 7'd0, 7'd0, 1'b1,1'b1,4'd7, 4'd10}   // R7 R10 trig 0
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             fifo_en = 1'b0;
    logic             blk_mode = 1'b0;
    logic [LVL_W-1:0] tx_level = '0;
    logic [LVL_W-1:0] rx_level = '0;
    logic [LVL_W-1:0] tx_trig = 7'd8;
    logic [LVL_W-1:0] rx_trig = 7'd8;
    logic             tx_rdy_n;
    logic             rx_rdy_n;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    dma_ready_gen #(.DEPTH(DEPTH)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .fifo_en  (fifo_en),
        .blk_mode (blk_mode),
        .tx_level (tx_level),
        .rx_level (rx_level),
        .tx_trig  (tx_trig),
        .rx_trig  (rx_trig),
        .tx_rdy_n (tx_rdy_n),
        .rx_rdy_n (rx_rdy_n)
    );

    task automatic chk(input logic act, input logic exp, input int rq, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: got %0b expected %0b", rq, what, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R2 watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: outputs idle while reset held
        repeat (3) @(negedge clk);
        chk(tx_rdy_n, 1'b1, 1, "reset tx");
        chk(rx_rdy_n, 1'b1, 1, "reset rx");
        rst = 1'b0;

        // Vector walk: drive at negedge, one rising edge, check at next negedge.
        for (int i = 0; i < NVEC; i++) begin
            fifo_en  = VEC[i].fe;
            blk_mode = VEC[i].bm;
            tx_level = VEC[i].txl;
            rx_level = VEC[i].rxl;
            tx_trig  = VEC[i].txt;
            rx_trig  = VEC[i].rxt;
            @(negedge clk);
            chk(tx_rdy_n, VEC[i].etx, int'(VEC[i].rtx), $sformatf("vec %0d tx", i));
            chk(rx_rdy_n, VEC[i].erx, int'(VEC[i].rrx), $sformatf("vec %0d rx", i));
        end

        // R2: a level change shows only after the next rising edge
        tx_level = 7'd0;
        rx_level = 7'd0;
        tx_trig  = 7'd8;
        rx_trig  = 7'd8;
        #1;
        chk(tx_rdy_n, 1'b1, 2, "before edge tx");
        @(posedge clk);
        #1;
        chk(tx_rdy_n, 1'b0, 2, "after edge tx");
        rx_level = 7'd9;
        #1;
        chk(rx_rdy_n, 1'b1, 2, "before edge rx");
        @(posedge clk);
        #1;
        chk(rx_rdy_n, 1'b0, 2, "after edge rx");

        // R1: reset from an active state returns both lines to idle
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(tx_rdy_n, 1'b1, 1, "mid-run reset tx");
        chk(rx_rdy_n, 1'b1, 1, "mid-run reset rx");

        // R8 R11: after reset, block style with levels below trigger keeps idle
        tx_level = 7'd60;
        rx_level = 7'd3;
        rst = 1'b0;
        @(negedge clk);
        chk(tx_rdy_n, 1'b1, 8, "hold after reset tx");
        chk(rx_rdy_n, 1'b1, 11, "hold after reset rx");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule